// File: doc/BRIEF.md
# Protected-Image Checksum Accumulator

This block walks a program memory image through a read port and produces the 16-bit checksum of that image. The checksum depends on whether the image is code-protected. With protection off, the whole user range is summed. With protection on, only the low unprotected segment is summed, and a word packed from the four identification locations is added. The configuration word, masked to its 12 valid bits, is always added. The calibration location at 0x3FF is never read and never summed.

A single-cycle `start` begins a run. The block reads the configuration word first, then the four ID words, then the main range in ascending address order. The read port has a latency of one cycle: data for an address issued in cycle t is presented in cycle t+1. When the run completes, `done` pulses for one cycle. `sum_out` then holds the result until the next accepted `start`.

The controller has six states:
- IDLE waits for `start` (transition *launch*).
- CFG_RD issues the configuration read (*to_ids*).
- ID_RD issues the four ID reads (*to_main* after the last one).
- MAIN_RD issues the main-range reads up to the limit chosen by protection (*to_drain* at the limit).
- DRAIN absorbs the final returning word (*to_finish*).
- FINISH folds in the packed ID word when protected (*retire*, back to IDLE).

Top module: `cks_image_checksum`

## Requirements
- R1: With protection off, `sum_out` equals the sum of words at addresses 0x000 through 0x3FE plus (configuration word AND 0xFFF), truncated to 16 bits.
- R2: With protection on, `sum_out` equals the sum of words at 0x000 through 0x03F, plus (configuration word AND 0xFFF), plus the packed ID word, truncated to 16 bits. No main-range address above 0x03F is read.
- R3: Address 0x3FF is never presented with `mem_rd` high, and its contents never affect `sum_out`.
- R4: The packed ID word is built from bits [3:0] of the words at 0x400, 0x401, 0x402 and 0x403. The word at 0x400 lands in bits [15:12] and the word at 0x403 lands in bits [3:0]. Bits [11:4] of each ID word are ignored. For example, IDs 0x012, 0x037, 0x004 and 0x026 pack to 0x2746.
- R5: The accumulation wraps modulo 2^16, and carries out of bit 15 are discarded.
- R6: Protection is on exactly when bits 11..6 and bit 4 of the configuration word are all zero. Bits 5 and 3..0 do not affect this decision.
- R7: After an accepted `start`, the reads are issued in this order, one per cycle:
  - 0xFFF (configuration word);
  - 0x400, 0x401, 0x402, 0x403;
  - the main range, ascending from 0x000.

  `mem_rdata` is taken one cycle after its address.
- R8: `done` is high for exactly one cycle per run. `sum_out` is then stable until the next accepted `start`.
- R9: After reset, `done` is 0, `sum_out` is 0 and `mem_rd` is 0. A `start` that arrives while a run is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run (sampled only in IDLE) |
| mem_rd | output | 1 | Read strobe to image memory |
| mem_addr | output | 12 | Read address |
| mem_rdata | input | 12 | Read data, valid one cycle after the strobe |
| sum_out | output | 16 | Checksum result |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench targets the protection decode edge. A configuration word with only bit 4 set, or only bit 11 set, must be treated as unprotected. A decoder that checks the wrong mask would drop almost the whole range from the sum. Separate cases give the calibration location and the ID upper bits non-zero values, so an off-by-one range end, or nibble packing in the wrong order or width, shows up as a wrong sum. An all-ones image forces many wraps past 16 bits, and a second `start` mid-run checks that a busy block neither restarts nor emits an extra `done`.

// File: rtl/cks_pkg.sv
package cks_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CFG_RD,
        ST_ID_RD,
        ST_MAIN_RD,
        ST_DRAIN,
        ST_FINISH
    } cks_state_e;

    typedef enum logic [1:0] {
        TAG_NONE,
        TAG_CFG,
        TAG_ID,
        TAG_MAIN
    } cks_tag_e;
endpackage

// File: rtl/cks_prot_decode.sv
module cks_prot_decode #(
    parameter int          WORD_W    = 12,
    parameter logic [11:0] PROT_MASK = 12'hFD0
) (
    input  logic [WORD_W-1:0] cfg_word,
    output logic              prot_on
);
    localparam logic [WORD_W-1:0] MASK_W = WORD_W'(PROT_MASK);

    // Protection is active when every masked bit is cleared.
    assign prot_on = ((cfg_word & MASK_W) == '0);
endmodule

// File: rtl/cks_id_packer.sv
module cks_id_packer #(
    parameter int WORD_W   = 12,
    parameter int NIB_W    = 4,
    parameter int ID_COUNT = 4,
    localparam int PACK_W  = NIB_W * ID_COUNT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              shift_en,
    input  logic [WORD_W-1:0] din,
    output logic [PACK_W-1:0] packed_id
);
    logic [PACK_W-1:0] pack_q;

    // The first ID shifted in ends up in the most significant nibble.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            pack_q <= '0;
        end else if (shift_en) begin
            pack_q <= {pack_q[PACK_W-NIB_W-1:0], din[NIB_W-1:0]};
        end
    end

    assign packed_id = pack_q;
endmodule

// File: rtl/cks_accum.sv
module cks_accum #(
    parameter int SUM_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             add_en,
    input  logic [SUM_W-1:0] add_val,
    output logic [SUM_W-1:0] sum
);
    logic [SUM_W-1:0] acc_q;

    // The SUM_W-bit adder drops the carry out of the top bit.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            acc_q <= '0;
        end else if (add_en) begin
            acc_q <= acc_q + add_val;
        end
    end

    assign sum = acc_q;

    AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (sum == '0)); // R9
endmodule

// File: rtl/cks_image_checksum.sv
module cks_image_checksum
    import cks_pkg::*;
#(
    parameter int              ADDR_W    = 12,
    parameter int              WORD_W    = 12,
    parameter int              SUM_W     = 16,
    parameter int              ID_COUNT  = 4,
    parameter int              NIB_W     = 4,
    parameter logic [ADDR_W-1:0] CFG_ADDR  = 12'hFFF,
    parameter logic [ADDR_W-1:0] ID_BASE   = 12'h400,
    parameter logic [ADDR_W-1:0] CAL_ADDR  = 12'h3FF,
    parameter logic [ADDR_W-1:0] PROT_LAST = 12'h03F,
    parameter logic [11:0]       PROT_MASK = 12'hFD0,
    parameter logic [WORD_W-1:0] CFG_MASK  = 12'hFFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic              mem_rd,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic [SUM_W-1:0]  sum_out,
    output logic              done
);
    localparam logic [ADDR_W-1:0] FULL_LAST = CAL_ADDR - 1'b1;
    localparam logic [ADDR_W-1:0] ID_LAST   = ADDR_W'(ID_COUNT - 1);
    localparam int                PACK_W    = NIB_W * ID_COUNT;

    cks_state_e state_q, state_d;
    cks_tag_e   tag_q, tag_d;
    logic [ADDR_W-1:0] ptr_q;
    logic [WORD_W-1:0] cfg_q;
    logic              done_q;
    logic              prot_on;
    logic [PACK_W-1:0] packed_id;
    logic [ADDR_W-1:0] main_last;
    logic              launch;
    logic              add_en;
    logic [SUM_W-1:0]  add_val;

    assign launch    = (state_q == ST_IDLE) && start;
    assign main_last = prot_on ? PROT_LAST : FULL_LAST;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (start) state_d = ST_CFG_RD;
            ST_CFG_RD:  state_d = ST_ID_RD;
            ST_ID_RD:   if (ptr_q == ID_LAST) state_d = ST_MAIN_RD;
            ST_MAIN_RD: if (ptr_q == main_last) state_d = ST_DRAIN;
            ST_DRAIN:   state_d = ST_FINISH;
            ST_FINISH:  state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // Outputs per state
    always_comb begin
        mem_rd   = 1'b0;
        mem_addr = '0;
        tag_d    = TAG_NONE;
        unique case (state_q)
            ST_CFG_RD: begin
                mem_rd   = 1'b1;
                mem_addr = CFG_ADDR;
                tag_d    = TAG_CFG;
            end
            ST_ID_RD: begin
                mem_rd   = 1'b1;
                mem_addr = ID_BASE + ptr_q;
                tag_d    = TAG_ID;
            end
            ST_MAIN_RD: begin
                mem_rd   = 1'b1;
                mem_addr = ptr_q;
                tag_d    = TAG_MAIN;
            end
            default: ;
        endcase
    end

    // Pointer, returning-data tag, configuration capture and done pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q  <= '0;
            tag_q  <= TAG_NONE;
            cfg_q  <= '0;
            done_q <= 1'b0;
        end else begin
            tag_q  <= tag_d;
            done_q <= (state_q == ST_FINISH);
            if (tag_q == TAG_CFG) cfg_q <= mem_rdata;
            if (state_q == ST_ID_RD)
                ptr_q <= (ptr_q == ID_LAST) ? '0 : ptr_q + 1'b1;
            else if (state_q == ST_MAIN_RD)
                ptr_q <= ptr_q + 1'b1;
            else
                ptr_q <= '0;
        end
    end

    always_comb begin
        add_en  = 1'b0;
        add_val = '0;
        if (tag_q == TAG_CFG) begin
            add_en  = 1'b1;
            add_val = SUM_W'(mem_rdata & CFG_MASK);
        end else if (tag_q == TAG_MAIN) begin
            add_en  = 1'b1;
            add_val = SUM_W'(mem_rdata);
        end else if (state_q == ST_FINISH && prot_on) begin
            add_en  = 1'b1;
            add_val = SUM_W'(packed_id);
        end
    end

    cks_prot_decode #(.WORD_W(WORD_W), .PROT_MASK(PROT_MASK)) u_prot (
        .cfg_word (cfg_q),
        .prot_on  (prot_on)
    );

    cks_id_packer #(.WORD_W(WORD_W), .NIB_W(NIB_W), .ID_COUNT(ID_COUNT)) u_pack (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (launch),
        .shift_en  (tag_q == TAG_ID),
        .din       (mem_rdata),
        .packed_id (packed_id)
    );

    cks_accum #(.SUM_W(SUM_W)) u_acc (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (launch),
        .add_en  (add_en),
        .add_val (add_val),
        .sum     (sum_out)
    );

    assign done = done_q;

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8
    AST_SUM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !start) |=> $stable(sum_out)); // R8
    AST_NO_CAL_READ: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |-> (mem_addr != CAL_ADDR)); // R3
    AST_PROT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_MAIN_RD && prot_on) |-> (mem_addr <= PROT_LAST)); // R2
    AST_CFG_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        launch |=> (mem_rd && mem_addr == CFG_ADDR)); // R7
    AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE && start) |=> (state_q != ST_CFG_RD)); // R9
endmodule

// File: tb/cks_image_checksum_tb_top.sv
module cks_image_checksum_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        mem_rd;
    logic [11:0] mem_addr;
    logic [11:0] mem_rdata = '0;
    logic [15:0] sum_out;
    logic        done;

    int checks = 0;
    int fails = 0;
    int done_cnt = 0;
    int rd_idx = 0;
    int seq_err = 0;
    int cal_reads = 0;
    bit prev_done = 1'b0;

    logic [15:0] exp_q[$];

    // Image model configuration
    logic [11:0] cfg_v;
    logic [11:0] id_v [4];
    logic [11:0] seed_v;
    bit          ones_v;
    bit          prot_exp;

    always #5 clk = ~clk;

    cks_image_checksum dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .mem_rd(mem_rd),
        .mem_addr(mem_addr), .mem_rdata(mem_rdata), .sum_out(sum_out), .done(done)
    );

    function automatic logic [11:0] model(input logic [11:0] a);
        if (a == 12'hFFF) return cfg_v;
        if (a >= 12'h400 && a <= 12'h403) return id_v[a - 12'h400];
        if (a == 12'h3FF) return 12'hABC;
        if (a <= 12'h3FE) return ones_v ? 12'hFFF : 12'(a * 7 + seed_v);
        return 12'h5A5;
    endfunction

    // Memory with one cycle of read latency
    always @(posedge clk) if (mem_rd) mem_rdata <= model(mem_addr);

    function automatic logic [15:0] expected_sum();
        logic [31:0] s;
        logic [11:0] last;
        s = 32'(cfg_v & 12'hFFF);
        prot_exp = ((cfg_v & 12'hFD0) == 12'h000);
        last = prot_exp ? 12'h03F : 12'h3FE;
        for (int a = 0; a <= int'(last); a++) s += 32'(model(12'(a)));
        if (prot_exp) s += {16'h0, id_v[0][3:0], id_v[1][3:0], id_v[2][3:0], id_v[3][3:0]};
        return s[15:0];
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Monitor: compares results, pulse width and read order
    always @(negedge clk) begin
        if (rst_n) begin
            if (done) begin
                done_cnt++;
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R8 unexpected done", 32'(sum_out), 32'h0);
                end else begin
                    logic [15:0] e;
                    e = exp_q.pop_front();
                    chk(sum_out == e, prot_exp ? "R2 R4 R5 protected sum" : "R1 R5 R6 unprotected sum",
                        32'(sum_out), 32'(e));
                end
                if (prev_done) chk(1'b0, "R8 done wider than one cycle", 32'd1, 32'd0);
            end
            prev_done = done;
            if (mem_rd) begin
                logic [11:0] ea;
                if (rd_idx == 0) ea = 12'hFFF;
                else if (rd_idx < 5) ea = 12'(12'h400 + rd_idx - 1);
                else ea = 12'(rd_idx - 5);
                if (mem_addr != ea) seq_err++;
                if (mem_addr == 12'h3FF) cal_reads++;
                rd_idx++;
            end
        end
    end

    task automatic run_case(input logic [11:0] cfg, input logic [11:0] i0, input logic [11:0] i1,
                            input logic [11:0] i2, input logic [11:0] i3, input logic [11:0] seed,
                            input bit ones, input bit poke_start);
        int base;
        int to;
        logic [15:0] e;
        cfg_v = cfg; id_v[0] = i0; id_v[1] = i1; id_v[2] = i2; id_v[3] = i3;
        seed_v = seed; ones_v = ones;
        e = expected_sum();
        exp_q.push_back(e);
        rd_idx = 0; seq_err = 0; cal_reads = 0;
        base = done_cnt;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        if (poke_start) begin
            repeat (20) @(negedge clk);
            start = 1'b1;
            @(negedge clk) start = 1'b0;
        end
        to = 0;
        while (done_cnt == base && to < 5000) begin
            @(negedge clk);
            to++;
        end
        chk(to < 5000, "R8 run completes (watchdog)", 32'(to), 32'd5000);
        chk(seq_err == 0, "R7 read order", 32'(seq_err), 32'd0);
        chk(cal_reads == 0, "R3 calibration location not read", 32'(cal_reads), 32'd0);
        repeat (3) @(negedge clk);
        chk(sum_out == e, "R8 result holds after done", 32'(sum_out), 32'(e));
        chk(done_cnt == base + 1, poke_start ? "R9 start while busy ignored" : "R8 single done",
            32'(done_cnt - base), 32'(1));
        chk(!mem_rd, "R9 idle after run", 32'(mem_rd), 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(done == 1'b0, "R9 reset done", 32'(done), 32'd0);
        chk(sum_out == 16'h0, "R9 reset sum", 32'(sum_out), 32'd0);
        chk(mem_rd == 1'b0, "R9 reset mem_rd", 32'(mem_rd), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: protection off, all config bits set
        run_case(12'hFFF, 12'h012, 12'h037, 12'h004, 12'h026, 12'h123, 1'b0, 1'b0);
        // R2 R4: protection on, example IDs pack to 0x2746
        run_case(12'h02F, 12'h012, 12'h037, 12'h004, 12'h026, 12'h055, 1'b0, 1'b0);
        // R6: only bit 4 set -> unprotected
        run_case(12'h010, 12'h001, 12'h002, 12'h003, 12'h004, 12'h300, 1'b0, 1'b0);
        // R6: only bit 11 set -> unprotected
        run_case(12'h800, 12'h00F, 12'h00E, 12'h00D, 12'h00C, 12'h0F0, 1'b0, 1'b0);
        // R4: upper ID bits set and ignored, protected
        run_case(12'h000, 12'hFF1, 12'hAB2, 12'h7C3, 12'h9D4, 12'h777, 1'b0, 1'b0);
        // R5: all-ones image wraps many times
        run_case(12'hFBF, 12'h000, 12'h000, 12'h000, 12'h000, 12'h000, 1'b1, 1'b0);
        // R9: start while busy is ignored
        run_case(12'h5AF, 12'h003, 12'h009, 12'h00A, 12'h00B, 12'h444, 1'b0, 1'b1);
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end
endmodule